// File: doc/BRIEF.md
# Word-Wide One-Way Programmable Memory Model

This block is a synthesizable stand-in for a one-time or window-erasable programmable memory of word-wide organisation. The pins of such a part are sampled on a clock and decoded into one operation per cycle: read, outputs off (standby or output disable), program, program verify, program inhibit, or identifier readout. The three-state data bus appears as a data-in word, a data-out word and a drive-enable flag. While the enable flag is low, the data-out word is forced to zero.

Programming can only move bits from 1 to 0. The word stored is the bitwise AND of the old content and the presented word. Only the erase input, or reset, brings every location back to all ones. The array is a single-port-write, single-port-read memory that can map onto block RAM. One blank flag per word stands for the erased state. A short forwarding path makes an operation that follows a program to the same address see the new word.

The result of an operation reaches the outputs after a fixed number of clock edges. This number is set by the `OUT_DELAY` parameter. Supply currents, analog levels and real access times are not modelled.

Top module: `wordwise_prom`

## Requirements
- R1: After reset, and after a cycle with `erase` high, every location reads as all ones (0xFFFF with default width).
- R2: With `ce_n`=0, `oe_n`=0, `prog_supply`=0 and `id_hv`=0, the stored word at `addr` is driven with `dout_en`=1. The result appears after the rising edge that comes 2+`OUT_DELAY` edges after the edge that samples the pins (3 edges with defaults).
- R3: With `ce_n`=1 (standby), or with `prog_supply`=0 and `oe_n`=1 (output disable), `dout_en` is 0 and `dout` is 0.
- R4: With `prog_supply`=1, `ce_n`=0, `oe_n`=1 and `prog_strobe_n`=0, the location becomes old AND `din`, and the outputs are off.
- R5: With `prog_supply`=1, any of these combinations leaves the array unchanged and the outputs off: `ce_n`=1, or `prog_strobe_n`=1 with `oe_n`=1, or `oe_n`=0 with `prog_strobe_n`=0.
- R6: With `prog_supply`=1, `ce_n`=0, `oe_n`=0 and `prog_strobe_n`=1, the stored word is driven with `dout_en`=1 (verify).
- R7: In read conditions with `id_hv`=1, the outputs show an identifier: `addr` bit 0 = 0 gives 0x0097, and bit 0 = 1 gives 0x00AB. The upper 8 bits read as zero.
- R8: A program never turns a 0 bit back into 1. Programming 0xFFFF over a programmed word leaves it unchanged.
- R9: An operation issued in the cycle right after a program to the same address sees the newly programmed word.
- R10: While `prog_supply`=0, `prog_strobe_n` has no effect. A low strobe neither writes nor changes what a read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; blanks the array and clears the pipeline |
| erase | input | 1 | Synchronous whole-array erase; also clears the pipeline |
| addr | input | AW | Word address |
| din | input | DW | Word to program |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_strobe_n | input | 1 | Program strobe, active low |
| prog_supply | input | 1 | Programming supply present |
| id_hv | input | 1 | High-voltage flag on address bit 9, selects identifier readout |
| dout | output | DW | Data out (zero while not driven) |
| dout_en | output | 1 | Data bus drive enable |

## Verification
If a blank flag is wrong, the next read or verify of that address returns the raw array word instead of 0xFFFF, or 0xFFFF instead of the programmed word. This shows three edges after that read is sampled. A missing forwarding path shows only when a read or verify follows a program to the same address in the next cycle: it returns the pre-program word. If a write is lost or merged wrongly (OR instead of AND), every later read of that location shows it. A decode error shows on the very next result as a wrong `dout_en`.

// File: rtl/prom_pkg.sv
package prom_pkg;

  // Operation carried down the pipeline; every outputs-off case folds into OP_IDLE.
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_READ   = 3'd1,
    OP_IDENT  = 3'd2,
    OP_PROG   = 3'd3,
    OP_VERIFY = 3'd4
  } prom_op_e;

endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
  import prom_pkg::*;
(
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     prog_strobe_n,
  input  logic     prog_supply,
  input  logic     id_hv,
  output prom_op_e op
);

  always_comb begin
    op = OP_IDLE;
    if (!ce_n) begin
      if (prog_supply) begin
        // supply present: strobe and output enable pick program or verify
        if (oe_n && !prog_strobe_n)      op = OP_PROG;
        else if (!oe_n && prog_strobe_n) op = OP_VERIFY;
        else                             op = OP_IDLE;
      end else if (!oe_n) begin
        op = id_hv ? OP_IDENT : OP_READ;
      end
    end
  end

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          erase,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] word_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rdata_q;
  logic [DEPTH-1:0] written;
  logic             written_q;
  logic             fwd_q;
  logic [DW-1:0]    fwd_data_q;
  logic [AW-1:0]    rd_addr_q;
  logic             write_ok;

  assign write_ok = wr_en && !erase;

  // plain array, no reset: maps onto block RAM (read-first)
  always_ff @(posedge clk) begin
    if (write_ok) mem[wr_addr] <= wr_data;
    rdata_q <= mem[rd_addr];
  end

  // one blank flag per word stands for the erased state
  always_ff @(posedge clk) begin
    if (rst || erase) written <= '0;
    else if (write_ok) written[wr_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || erase) begin
      written_q  <= 1'b0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
      rd_addr_q  <= '0;
    end else begin
      written_q  <= written[rd_addr];
      fwd_q      <= write_ok && (wr_addr == rd_addr);
      fwd_data_q <= wr_data;
      rd_addr_q  <= rd_addr;
    end
  end

  assign word_o = fwd_q ? fwd_data_q : (written_q ? rdata_q : '1);

  // R8
  only_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr == rd_addr_q) && ((wr_data & ~word_o) == '0));

  // R1
  erase_blank_chk: assert property (@(posedge clk) disable iff (rst)
    erase |=> (word_o == '1));

  // R4
  write_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !erase) |=> written[$past(wr_addr)]);

endmodule

// File: rtl/prom_out_delay.sv
module prom_out_delay #(
  parameter int W      = 16,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         d_en,
  input  logic [W-1:0] d_data,
  output logic         q_en,
  output logic [W-1:0] q_data
);

  if (STAGES == 0) begin : g_direct
    assign q_en   = d_en;
    assign q_data = d_data;
  end else begin : g_pipe
    logic [STAGES-1:0] en_r;
    logic [W-1:0]      dat_r [STAGES];

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        en_r <= '0;
        for (int i = 0; i < STAGES; i++) dat_r[i] <= '0;
      end else begin
        en_r[0]  <= d_en;
        dat_r[0] <= d_data;
        for (int i = 1; i < STAGES; i++) begin
          en_r[i]  <= en_r[i-1];
          dat_r[i] <= dat_r[i-1];
        end
      end
    end

    assign q_en   = en_r[STAGES-1];
    assign q_data = dat_r[STAGES-1];
  end

endmodule

// File: rtl/wordwise_prom.sv
module wordwise_prom
  import prom_pkg::*;
#(
  parameter int         AW        = 10,
  parameter int         DW        = 16,
  parameter int         OUT_DELAY = 1,
  parameter logic [7:0] ID_LOW    = 8'h97,
  parameter logic [7:0] ID_HIGH   = 8'hAB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          prog_strobe_n,
  input  logic          prog_supply,
  input  logic          id_hv,
  output logic [DW-1:0] dout,
  output logic          dout_en
);

  prom_op_e      op_pins;
  prom_op_e      op_s1, op_s2;
  logic [AW-1:0] addr_s1, addr_s2;
  logic [DW-1:0] din_s1, din_s2;
  logic [DW-1:0] cur_word;
  logic [DW-1:0] id_word;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          oreg_en;
  logic [DW-1:0] oreg_data;

  prom_mode_decode u_decode (
    .ce_n          (ce_n),
    .oe_n          (oe_n),
    .prog_strobe_n (prog_strobe_n),
    .prog_supply   (prog_supply),
    .id_hv         (id_hv),
    .op            (op_pins)
  );

  // stage 1: sampled pins; stage 2: array word available
  always_ff @(posedge clk) begin
    if (rst || erase) begin
      op_s1   <= OP_IDLE;
      addr_s1 <= '0;
      din_s1  <= '0;
      op_s2   <= OP_IDLE;
      addr_s2 <= '0;
      din_s2  <= '0;
    end else begin
      op_s1   <= op_pins;
      addr_s1 <= addr;
      din_s1  <= din;
      op_s2   <= op_s1;
      addr_s2 <= addr_s1;
      din_s2  <= din_s1;
    end
  end

  prom_cell_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .rst     (rst),
    .erase   (erase),
    .rd_addr (addr_s1),
    .wr_en   (wr_en),
    .wr_addr (addr_s2),
    .wr_data (wr_data),
    .word_o  (cur_word)
  );

  assign wr_en   = (op_s2 == OP_PROG);
  assign wr_data = cur_word & din_s2;

  always_comb begin
    id_word      = '0;
    id_word[7:0] = addr_s2[0] ? ID_HIGH : ID_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst || erase) begin
      oreg_en   <= 1'b0;
      oreg_data <= '0;
    end else begin
      unique case (op_s2)
        OP_READ, OP_VERIFY: begin oreg_en <= 1'b1; oreg_data <= cur_word; end
        OP_IDENT:           begin oreg_en <= 1'b1; oreg_data <= id_word;  end
        default:            begin oreg_en <= 1'b0; oreg_data <= '0;       end
      endcase
    end
  end

  prom_out_delay #(.W(DW), .STAGES(OUT_DELAY)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .flush  (erase),
    .d_en   (oreg_en),
    .d_data (oreg_data),
    .q_en   (dout_en),
    .q_data (dout)
  );

  // R3
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0));

endmodule

// File: tb/wordwise_prom_tb.sv
module wordwise_prom_tb;

  localparam int AW   = 10;
  localparam int DW   = 16;
  localparam int LATC = 4;  // negedges from drive to sample, OUT_DELAY = 1

  typedef struct {
    logic          en;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          prog_strobe_n = 1'b1;
  logic          prog_supply = 1'b0;
  logic          id_hv = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  exp_t q[$];
  logic [DW-1:0] model [1 << AW];

  always #5 clk = ~clk;

  wordwise_prom u_dut (
    .clk           (clk),
    .rst           (rst),
    .erase         (erase),
    .addr          (addr),
    .din           (din),
    .ce_n          (ce_n),
    .oe_n          (oe_n),
    .prog_strobe_n (prog_strobe_n),
    .prog_supply   (prog_supply),
    .id_hv         (id_hv),
    .dout          (dout),
    .dout_en       (dout_en)
  );

  task automatic apply(input logic ce, input logic oe, input logic ps, input logic sup,
                       input logic hv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string tag);
    exp_t e;
    @(negedge clk);
    erase = 1'b0; ce_n = ce; oe_n = oe; prog_strobe_n = ps;
    prog_supply = sup; id_hv = hv; addr = a; din = d;
    e.en = 1'b0; e.d = '0; e.tag = tag;
    if (!ce) begin
      if (sup) begin
        if (oe && !ps) model[a] = model[a] & d;
        else if (!oe && ps) begin e.en = 1'b1; e.d = model[a]; end
      end else if (!oe) begin
        e.en = 1'b1;
        e.d  = hv ? (a[0] ? 16'h00AB : 16'h0097) : model[a];
      end
    end
    q.push_back(e);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, '0, tag);
  endtask
  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, d, tag);
  endtask
  task automatic ver(input logic [AW-1:0] a, input string tag);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, a, '0, tag);
  endtask
  task automatic ident(input logic [AW-1:0] a, input string tag);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, '0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0, "R3");
  endtask

  task automatic do_erase();
    exp_t e;
    idle(LATC);
    @(negedge clk);
    erase = 1'b1; ce_n = 1'b1; oe_n = 1'b1; prog_strobe_n = 1'b1; prog_supply = 1'b0;
    e.en = 1'b0; e.d = '0; e.tag = "R1";
    q.push_back(e);
    for (int i = 0; i < (1 << AW); i++) model[i] = '1;
  endtask

  // monitor: pops the expected item due at this negedge
  always @(negedge clk) begin
    #1;
    if (q.size() > LATC) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (dout_en !== e.en || dout !== e.d) begin
        n_fails++;
        $display("FAIL %s: got en=%0b dout=%h, expected en=%0b dout=%h",
                 e.tag, dout_en, dout, e.en, e.d);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    n_checks++;
    if (dout_en !== 1'b0 || dout !== '0) begin
      n_fails++;
      $display("FAIL R3 reset: got en=%0b dout=%h, expected en=0 dout=0000", dout_en, dout);
    end

    // R1 blank reads, R2 read timing
    rd(10'd0, "R1"); rd(10'd5, "R1"); rd(10'd1023, "R1");
    // R4 program then R9 immediate read of the same address
    prog(10'd5, 16'hF0F0, "R4");
    rd(10'd5, "R9");
    rd(10'd6, "R2");
    // R8 ones do not restore bits; AND merge
    prog(10'd5, 16'hFFFF, "R8");
    rd(10'd5, "R8");
    prog(10'd5, 16'h3CFF, "R4");
    ver(10'd5, "R9");
    // R6 verify
    ver(10'd6, "R6");
    // R7 identifier
    ident(10'd0, "R7"); ident(10'd1, "R7");
    // R3 standby and output disable
    apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5, '0, "R3");
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd5, '0, "R3");
    // R5 inhibit cases, then readback
    apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd5, 16'h0000, "R5");
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd5, 16'h0000, "R5");
    apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd5, 16'h0000, "R5");
    rd(10'd5, "R5");
    // R10 strobe without supply
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd7, 16'h0000, "R10");
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd7, 16'h0000, "R10");
    rd(10'd7, "R10");
    // boundary address
    prog(10'd1023, 16'h1234, "R4");
    idle(2);
    rd(10'd1023, "R2");
    // walking zeros across a range, then R8 overwrite with ones
    for (int i = 0; i < 16; i++) prog(10'(16 + i), ~(16'h1 << i), "R4");
    for (int i = 0; i < 16; i++) rd(10'(16 + i), "R2");
    for (int i = 0; i < 16; i++) begin
      prog(10'(16 + i), 16'hFFFF, "R8");
      ver(10'(16 + i), "R8");
    end
    // R1 erase
    do_erase();
    rd(10'd5, "R1"); rd(10'd1023, "R1"); ver(10'd20, "R1");
    prog(10'd5, 16'h00FF, "R4");
    rd(10'd5, "R9");
    idle(LATC + 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule